// File: doc/BRIEF.md
# Configurable Parallel Host Port

This block is the slave end of a parallel host bus. An external host moves 16-bit words into an input register and out of an output register. It can do this over an 8-bit or a 16-bit data bus. On the core side, logic loads the output register, takes words from the input register and reads two buffer flags. The flags are input-full (a host word is waiting) and output-empty (the host has taken the last word).

A configuration word written from the core sets the behaviour at runtime:
- the external bus width;
- whether a word moves as one byte or as two byte accesses;
- whether byte select is inverted;
- whether the two bytes are swapped on a wide bus;
- whether the host uses separate read and write strobes, or a read/write line with one data strobe of selectable polarity;
- the polarity of the two flag pins, and whether the input-full pin also carries the output-empty state;
- the polarity of output-empty as the core sees it.

Every host strobe and the byte select pass through two-flop synchronizers. A host access takes effect when its strobe is released. The data pins are driven only while a read strobe is active.

Top module: `par_host_port`

## Requirements
- R1: After reset the configuration is all zero, input-full is 0, output-empty is 1, no data lane is enabled, `pin_ibf` is 0 and `pin_obe` is 1.
- R2: Configuration bit 7 selects the bus width. At 0 the bus is 8 bits: only lane 0 (`hst_doe[0]`, data bits 7..0) is ever enabled and bits 15..8 stay released. At 1 a read enables both lanes.
- R3: Configuration bit 6 sets the polarity of `stat_obe`: it equals the output-empty flag when the bit is 0 and its inverse when the bit is 1.
- R4: Configuration bit 5 selects what `pin_ibf` shows. At 0 it shows input-full alone. At 1 it shows input-full OR output-empty. `pin_obe` is the same either way.
- R5: Configuration bit 4 sets the polarity of both flag pins: 0 gives active-high and 1 gives active-low.
- R6: On an 8-bit bus with bit 0 = 1, the high byte is addressed when `hst_bsel` XOR configuration bit 3 is 1 and the low byte otherwise. On an 8-bit bus with bit 0 = 0, every access addresses the low byte whatever `hst_bsel` is.
- R7: With configuration bit 1 = 0, `hst_rd_n` and `hst_wr_n` are active-low read and write strobes, and `hst_rw`/`hst_ds` are ignored.
- R8: With configuration bit 1 = 1, `hst_ds` is the strobe (active-low when bit 2 is 0, active-high when bit 2 is 1) and `hst_rw` = 1 marks a read and 0 a write. `hst_rd_n`/`hst_wr_n` are ignored in this mode.
- R9: On a 16-bit bus, configuration bit 0 = 0 keeps byte positions and 1 swaps the high and low bytes, for both reads and writes.
- R10: Input-full sets when a host write that completes a word is released. On a wide bus, or in 8-bit transfers, every write completes a word. In two-byte mode only a high-byte write completes a word. A core read (`core_rd`) clears it.
- R11: Output-empty sets when a host read that completes a word is released, under the same word rule as R10. A core write (`core_wr`) clears it and loads the output register.
- R12: The data lanes are enabled only while a host read strobe, seen through the synchronizer, is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 12 | Configuration word; bits 11..8 reserved, written as zero |
| core_wr | input | 1 | Core loads the output register |
| core_wdata | input | 16 | Word for the output register |
| core_rd | input | 1 | Core takes the input register |
| core_rdata | output | 16 | Input register contents |
| stat_ibf | output | 1 | Input-full status |
| stat_obe | output | 1 | Output-empty status, polarity per bit 6 |
| hst_rd_n | input | 1 | Separate-strobe mode read strobe, active-low |
| hst_wr_n | input | 1 | Separate-strobe mode write strobe, active-low |
| hst_rw | input | 1 | Single-strobe mode direction, 1 = read |
| hst_ds | input | 1 | Single-strobe mode data strobe |
| hst_bsel | input | 1 | Byte select |
| hst_din | input | 16 | Host data into the port |
| hst_dout | output | 16 | Data driven to the host |
| hst_doe | output | 2 | Lane enables: bit 0 for bits 7..0, bit 1 for bits 15..8 |
| pin_ibf | output | 1 | Input-full flag pin |
| pin_obe | output | 1 | Output-empty flag pin |

## Verification
The bench aims at the byte-lane corners. These are a two-byte transfer where only the high byte may raise a flag, inverted byte select, 8-bit mode ignoring byte select, and swapping on the wide bus. A design that got these wrong would raise a flag after half a word, or put a byte in the wrong half. It also drives strobe pins that belong to the mode not in use and checks that nothing happens. A port that decoded both strobe sets would then drive the bus or move the flags. Random configurations cover the flag-pin polarity and merge options, where a wrong XOR or OR shows up as an inverted or stuck pin.

// File: rtl/par_host_port.sv
module par_host_port #(
  parameter int SYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [11:0] cfg_wdata,
  input  logic        core_wr,
  input  logic [15:0] core_wdata,
  input  logic        core_rd,
  output logic [15:0] core_rdata,
  output logic        stat_ibf,
  output logic        stat_obe,
  input  logic        hst_rd_n,
  input  logic        hst_wr_n,
  input  logic        hst_rw,
  input  logic        hst_ds,
  input  logic        hst_bsel,
  input  logic [15:0] hst_din,
  output logic [15:0] hst_dout,
  output logic [1:0]  hst_doe,
  output logic        pin_ibf,
  output logic        pin_obe
);
  localparam int TOP = SYNC - 1;

  logic [7:0]    cfg;
  logic [15:0]   in_q, out_q;
  logic          ibf, obe;
  logic [TOP:0]  s_rd, s_wr, s_rw, s_ds, s_bs;
  logic          rd_q, wr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_rd <= '1; s_wr <= '1; s_rw <= '0; s_ds <= '1; s_bs <= '0;
    end else begin
      s_rd <= {s_rd[TOP-1:0], hst_rd_n};
      s_wr <= {s_wr[TOP-1:0], hst_wr_n};
      s_rw <= {s_rw[TOP-1:0], hst_rw};
      s_ds <= {s_ds[TOP-1:0], hst_ds};
      s_bs <= {s_bs[TOP-1:0], hst_bsel};
    end

  wire wide   = cfg[7];
  wire moto   = cfg[1];
  wire xfer16 = cfg[0];

  wire ds_on  = cfg[2] ? s_ds[TOP] : ~s_ds[TOP];
  wire rd_act = moto ? (ds_on &  s_rw[TOP]) : ~s_rd[TOP];
  wire wr_act = moto ? (ds_on & ~s_rw[TOP]) : ~s_wr[TOP];
  wire rd_done = rd_q & ~rd_act;
  wire wr_done = wr_q & ~wr_act;

  wire hi_sel   = s_bs[TOP] ^ cfg[3];
  wire word_end = wide | ~xfer16 | hi_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg <= '0;
    else if (cfg_we) cfg <= cfg_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_q <= '0;
    else if (core_wr) out_q <= core_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) in_q <= '0;
    else if (wr_done) begin
      if (wide)                 in_q <= xfer16 ? {hst_din[7:0], hst_din[15:8]} : hst_din;
      else if (xfer16 & hi_sel) in_q[15:8] <= hst_din[7:0];
      else                      in_q[7:0]  <= hst_din[7:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ibf <= 1'b0;
      obe <= 1'b1;
    end else begin
      if (wr_done & word_end) ibf <= 1'b1;
      else if (core_rd)       ibf <= 1'b0;
      if (rd_done & word_end) obe <= 1'b1;
      else if (core_wr)       obe <= 1'b0;
    end

  assign hst_dout = wide ? (xfer16 ? {out_q[7:0], out_q[15:8]} : out_q)
                         : {8'h00, (xfer16 & hi_sel) ? out_q[15:8] : out_q[7:0]};
  assign hst_doe  = {rd_act & wide, rd_act};

  assign core_rdata = in_q;
  assign stat_ibf   = ibf;
  assign stat_obe   = obe ^ cfg[6];
  assign pin_ibf    = (cfg[5] ? (ibf | obe) : ibf) ^ cfg[4];
  assign pin_obe    = obe ^ cfg[4];

  assert_drive_needs_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!moto && hst_doe[0]) |-> !$past(hst_rd_n, SYNC));

  assert_ibf_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd && !(wr_done && word_end)) |=> !stat_ibf);

  assert_obe_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr && !cfg_we && !(rd_done && word_end)) |=> (stat_obe == cfg[6]));

  assert_pin_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[4] && stat_ibf) |-> pin_ibf);

  assert_pin_polarity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[4] && !cfg[6]) |-> (pin_obe == stat_obe));
endmodule

// File: tb/par_host_port_tb.sv
module par_host_port_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, core_wr = 0, core_rd = 0;
  logic [11:0] cfg_wdata = '0;
  logic [15:0] core_wdata = '0, hst_din = '0;
  logic hst_rd_n = 1, hst_wr_n = 1, hst_rw = 0, hst_ds = 1, hst_bsel = 0;
  logic [15:0] core_rdata, hst_dout;
  logic [1:0]  hst_doe;
  logic stat_ibf, stat_obe, pin_ibf, pin_obe;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0]  cur = '0;
  logic [15:0] m_in = '0, m_out = '0;
  logic m_ibf = 0, m_obe = 1;

  always #4 clk = ~clk;

  par_host_port u_dut (.*);

  function automatic logic [15:0] swp(logic [15:0] x);
    return {x[7:0], x[15:8]};
  endfunction

  function automatic logic exp_pin_ibf(logic [7:0] c, logic i, logic o);
    return (c[5] ? (i | o) : i) ^ c[4];
  endfunction

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(string req);
    chk(stat_ibf == m_ibf, req, 16'(stat_ibf), 16'(m_ibf));
    chk(stat_obe == (m_obe ^ cur[6]), req, 16'(stat_obe), 16'(m_obe ^ cur[6]));
    chk(pin_ibf == exp_pin_ibf(cur, m_ibf, m_obe), req, 16'(pin_ibf), 16'(exp_pin_ibf(cur, m_ibf, m_obe)));
    chk(pin_obe == (m_obe ^ cur[4]), req, 16'(pin_obe), 16'(m_obe ^ cur[4]));
    chk(core_rdata == m_in, req, core_rdata, m_in);
    chk(hst_doe == 2'b00, "R12 idle", 16'(hst_doe), 16'h0);
  endtask

  task automatic set_cfg(logic [7:0] c);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = {4'h0, c & 8'hFD};
    hst_ds = ~c[2];
    @(negedge clk); cfg_we = 0;
    repeat (6) @(negedge clk);
    cfg_we = 1; cfg_wdata = {4'h0, c};
    @(negedge clk); cfg_we = 0;
    cur = c;
    repeat (4) @(negedge clk);
  endtask

  task automatic core_write(logic [15:0] v);
    @(negedge clk); core_wr = 1; core_wdata = v;
    @(negedge clk); core_wr = 0;
    m_out = v; m_obe = 0;
  endtask

  task automatic core_read();
    @(negedge clk); core_rd = 1;
    @(negedge clk); core_rd = 0;
    m_ibf = 0;
  endtask

  task automatic access(bit rd, logic b, logic [15:0] d, string req);
    logic hi, wend;
    logic [15:0] ev;
    hi   = b ^ cur[3];
    wend = cur[7] | ~cur[0] | hi;
    @(negedge clk);
    hst_bsel = b; hst_din = d;
    if (cur[1]) begin hst_rw = rd; hst_ds = cur[2]; end
    else if (rd) hst_rd_n = 0;
    else hst_wr_n = 0;
    repeat (5) @(negedge clk);
    if (rd) begin
      if (cur[7]) begin
        ev = cur[0] ? swp(m_out) : m_out;
        chk(hst_doe == 2'b11, req, 16'(hst_doe), 16'h3);
        chk(hst_dout == ev, req, hst_dout, ev);
      end else begin
        ev = {8'h00, (cur[0] & hi) ? m_out[15:8] : m_out[7:0]};
        chk(hst_doe == 2'b01, {req, " R2"}, 16'(hst_doe), 16'h1);
        chk(hst_dout[7:0] == ev[7:0], req, {8'h00, hst_dout[7:0]}, ev);
      end
    end
    hst_rd_n = 1; hst_wr_n = 1;
    if (cur[1]) hst_ds = ~cur[2];
    repeat (6) @(negedge clk);
    if (rd) begin
      if (wend) m_obe = 1;
    end else begin
      if (cur[7]) m_in = cur[0] ? swp(d) : d;
      else if (cur[0] & hi) m_in[15:8] = d[7:0];
      else m_in[7:0] = d[7:0];
      if (wend) m_ibf = 1;
    end
    chk_state(req);
  endtask

  task automatic foreign_pulse(string req);
    @(negedge clk);
    if (cur[1]) begin hst_rd_n = 0; hst_wr_n = 0; end
    else begin hst_rw = 1; hst_ds = ~hst_ds; end
    repeat (5) @(negedge clk);
    chk(hst_doe == 2'b00, req, 16'(hst_doe), 16'h0);
    hst_rd_n = 1; hst_wr_n = 1;
    if (!cur[1]) hst_ds = ~hst_ds;
    repeat (6) @(negedge clk);
    chk_state(req);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_state("R1 reset");
    chk(pin_ibf == 0 && pin_obe == 1, "R1 pins", {14'h0, pin_ibf, pin_obe}, 16'h1);

    set_cfg(8'h80);
    core_write(16'hA55A);
    chk_state("R11 core write clears");
    access(1, 0, 16'h0, "R7 R2 wide read");
    access(0, 0, 16'h1234, "R7 R10 wide write");
    core_read();
    chk_state("R10 core read clears");

    set_cfg(8'h81);
    core_write(16'hBEEF);
    access(1, 0, 16'h0, "R9 swap read");
    access(0, 0, 16'hC0DE, "R9 swap write");
    core_read();

    set_cfg(8'h01);
    access(0, 0, 16'h00CD, "R6 R10 low byte no flag");
    access(0, 1, 16'h00AB, "R6 R10 high byte completes");
    core_read();
    core_write(16'h5AA5);
    access(1, 0, 16'h0, "R6 R11 low byte read");
    access(1, 1, 16'h0, "R6 R11 high byte read");

    set_cfg(8'h09);
    access(0, 0, 16'h0077, "R6 inverted select high");
    access(0, 1, 16'h0066, "R6 inverted select low");
    core_read();

    set_cfg(8'h00);
    access(0, 1, 16'h0042, "R6 8-bit ignores select");
    foreign_pulse("R7 ignores single-strobe pins");

    set_cfg(8'h40);
    chk_state("R3 status polarity");
    set_cfg(8'h20);
    core_write(16'h1111);
    chk_state("R4 merge");
    set_cfg(8'h30);
    chk_state("R5 R4 pin polarity");

    set_cfg(8'h82);
    core_write(16'h9876);
    access(1, 0, 16'h0, "R8 low strobe read");
    access(0, 0, 16'h4321, "R8 low strobe write");
    foreign_pulse("R8 ignores separate strobes");
    set_cfg(8'h86);
    core_write(16'h2468);
    access(1, 0, 16'h0, "R8 high strobe read");
    access(0, 0, 16'h1357, "R8 high strobe write");

    for (int i = 0; i < 300; i++) begin
      if (i % 20 == 0) set_cfg(8'($urandom));
      case ($urandom % 4)
        0: access(0, 1'($urandom), 16'($urandom), "R10 random write");
        1: access(1, 1'($urandom), 16'h0, "R11 random read");
        2: begin core_write(16'($urandom)); chk_state("R11 random core write"); end
        default: begin core_read(); chk_state("R10 random core read"); end
      endcase
    end

    finished = 1;
    report();
  end
endmodule